// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets a clocked design read and write one external asynchronous static RAM of one-megaword by four-bit organization. On the user side a single request carries a direction flag, a word address and a write nibble. The controller accepts it when it is free, runs one complete memory cycle on the active-low chip-enable, write-enable and output-enable strobes, and answers with a one-cycle completion pulse. For a read, the pulse carries the nibble captured from the memory.

Every phase of a memory cycle lasts a whole number of clocks. That number is derived at elaboration time from nanosecond timing limits and a clock-period parameter: the limit is divided by the period, rounded up, and never taken below one clock. Writes are controlled by write enable, and output enable stays inactive for the whole write. The data bus is driven only after the memory output has had time to go high-impedance. When the transfer direction changes, one idle turnaround clock separates the two cycles.

The data bus is brought out as a separate output value, drive-enable and input value. The pad itself sits outside the block.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it: req_ready is 1, rsp_done is 0, mem_ce_n, mem_we_n and mem_oe_n are 1, and mem_dq_oe is 0.
- R2: A request is taken only on a rising edge where req_valid and req_ready are both 1. req_valid pulses while busy are dropped and are not queued, so after completion the strobes stay inactive until a new request is made.
- R3: A read (req_write = 0) holds mem_ce_n = 0, mem_oe_n = 0 and mem_we_n = 1 with the accepted address on mem_addr for RD_LEN cycles. RD_LEN = max(ceil(T_AA_NS/CLK_PERIOD_NS), ceil(T_RC_NS/CLK_PERIOD_NS), 1).
- R4: Read data is sampled on the edge that ends the last read cycle. In the next cycle rsp_done is 1 for exactly one cycle with rsp_rdata holding that nibble, all strobes are inactive and req_ready is 1.
- R5: A write (req_write = 1) keeps mem_oe_n = 1 throughout and runs in three phases. First, HZ_LEN cycles with mem_ce_n = mem_we_n = 0 and the bus undriven; HZ_LEN = max(ceil(T_HZWE_NS), ceil(T_HZOE_NS), 1) in clocks. Second, DRV_LEN cycles with the same strobes and mem_dq_oe = 1; DRV_LEN = max(ceil(T_DS_NS), WLOW - HZ_LEN, WC - HZ_LEN - 1, 1), where WLOW is the largest of the rounded write-pulse, chip-enable-to-end and address-to-end limits and WC is the rounded write cycle time. The bus is never driven while mem_oe_n is 0.
- R6: Address and write data are registered at acceptance and stay stable until completion. After mem_we_n rises there is one hold cycle with mem_ce_n = mem_we_n = 1 in which mem_dq_oe is still 1 and mem_dq_o and mem_addr are unchanged.
- R7: When the accepted direction differs from that of the previous cycle since reset, one turnaround cycle with all strobes at 1 and mem_dq_oe = 0 comes before the new cycle's strobes. Otherwise, and for the first request after reset, the strobes begin in the cycle after acceptance.
- R8: A write completes in the cycle after its hold cycle. In that cycle rsp_done is 1 for one cycle, mem_dq_oe returns to 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write nibble |
| req_ready | output | 1 | Controller free to accept |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read nibble, valid with rsp_done after a read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_o | output | DATA_W | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive-enable |
| mem_dq_i | input | DATA_W | Value read from the data bus |

## Verification
The embedded properties check a set of rules on every cycle:
- Output enable stays inactive whenever write enable is low or the bus is driven.
- Drive is switched on only after a cycle with write enable already low.
- Data and address are held across the rising write strobe and stay frozen while the controller is busy.
- The completion pulse lasts one cycle.

The exact phase lengths, the edge on which read data is captured, the turnaround cycle on a direction change, and the dropping of requests made while busy are shown only by the bench's scenarios. These scenarios sweep every address of a small configuration against a memory model that returns unknown data until the access time has elapsed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_TURN    = 3'd1,
        ST_READ    = 3'd2,
        ST_WR_HZ   = 3'd3,
        ST_WR_DRV  = 3'd4,
        ST_WR_HOLD = 3'd5
    } phase_e;

    // Whole clocks covering a limit in ns, never below one.
    function automatic int cycles_for(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_req_capture.sv
module sram_req_capture #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    req_t req_d, req_q;

    // R6: fields change only at acceptance
    always_comb begin
        req_d = req_q;
        if (load_i) begin
            req_d.wr    = wr_i;
            req_d.addr  = addr_i;
            req_d.wdata = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign wr_o    = req_q.wr;
    assign addr_o  = req_q.addr;
    assign wdata_o = req_q.wdata;

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] rdata_d, rdata_q;

    // R4: capture on the edge closing the read phase
    always_comb begin
        rdata_d = rdata_q;
        if (sample_i) rdata_d = dq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 4,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RC_NS       = 8,
    parameter int T_AA_NS       = 8,
    parameter int T_WC_NS       = 8,
    parameter int T_WP_NS       = 7,
    parameter int T_CW_NS       = 7,
    parameter int T_AW_NS       = 7,
    parameter int T_DS_NS       = 5,
    parameter int T_HZWE_NS     = 4,
    parameter int T_HZOE_NS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    // Phase lengths in clocks (R3, R5)
    localparam int RD_LEN  = max2(cycles_for(T_AA_NS, CLK_PERIOD_NS),
                                  cycles_for(T_RC_NS, CLK_PERIOD_NS));
    localparam int HZ_LEN  = max2(cycles_for(T_HZWE_NS, CLK_PERIOD_NS),
                                  cycles_for(T_HZOE_NS, CLK_PERIOD_NS));
    localparam int WLOW    = max2(cycles_for(T_WP_NS, CLK_PERIOD_NS),
                                  max2(cycles_for(T_CW_NS, CLK_PERIOD_NS),
                                       cycles_for(T_AW_NS, CLK_PERIOD_NS)));
    localparam int WC_LEN  = cycles_for(T_WC_NS, CLK_PERIOD_NS);
    localparam int DRV_LEN = max2(max2(cycles_for(T_DS_NS, CLK_PERIOD_NS), WLOW - HZ_LEN),
                                  max2(WC_LEN - HZ_LEN - 1, 1));
    localparam int MAX_LEN = max2(RD_LEN, max2(HZ_LEN, DRV_LEN));
    localparam int CNT_W   = $clog2(MAX_LEN) + 1;
    localparam logic [CNT_W-1:0] RD_M1  = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] HZ_M1  = CNT_W'(HZ_LEN - 1);
    localparam logic [CNT_W-1:0] DRV_M1 = CNT_W'(DRV_LEN - 1);

    typedef struct packed {
        phase_e phase;
        logic   ce_n;
        logic   we_n;
        logic   oe_n;
        logic   dq_oe;
        logic   done;
        logic   has_last;
        logic   last_wr;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{phase: ST_IDLE, ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                   dq_oe: 1'b0, done: 1'b0, has_last: 1'b0, last_wr: 1'b0};

    ctrl_t            c_d, c_q;
    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             sample;
    logic             cap_wr;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    sram_req_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .wr_i    (req_write),
        .addr_i  (req_addr),
        .wdata_i (req_wdata),
        .wr_o    (cap_wr),
        .addr_o  (mem_addr),
        .wdata_o (mem_dq_o)
    );

    sram_read_capture #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .dq_i     (mem_dq_i),
        .rdata_o  (rsp_rdata)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sample   = 1'b0;
        accept   = req_valid && (c_q.phase == ST_IDLE);   // R2

        unique case (c_q.phase)
            ST_IDLE: begin
                if (accept) begin
                    c_d.has_last = 1'b1;
                    c_d.last_wr  = req_write;
                    if (c_q.has_last && (c_q.last_wr != req_write)) begin
                        c_d.phase = ST_TURN;                    // R7
                    end else if (req_write) begin
                        c_d.phase = ST_WR_HZ;
                        tmr_load  = 1'b1;
                        tmr_val   = HZ_M1;
                    end else begin
                        c_d.phase = ST_READ;
                        tmr_load  = 1'b1;
                        tmr_val   = RD_M1;
                    end
                end
            end
            ST_TURN: begin
                tmr_load = 1'b1;
                if (cap_wr) begin
                    c_d.phase = ST_WR_HZ;
                    tmr_val   = HZ_M1;
                end else begin
                    c_d.phase = ST_READ;
                    tmr_val   = RD_M1;
                end
            end
            ST_READ: begin
                if (tmr_zero) begin
                    c_d.phase = ST_IDLE;
                    c_d.done  = 1'b1;
                    sample    = 1'b1;                           // R4
                end
            end
            ST_WR_HZ: begin
                if (tmr_zero) begin
                    c_d.phase = ST_WR_DRV;
                    tmr_load  = 1'b1;
                    tmr_val   = DRV_M1;
                end
            end
            ST_WR_DRV: begin
                if (tmr_zero) c_d.phase = ST_WR_HOLD;           // R6
            end
            ST_WR_HOLD: begin
                c_d.phase = ST_IDLE;
                c_d.done  = 1'b1;                               // R8
            end
            default: c_d.phase = ST_IDLE;
        endcase

        // Registered strobes follow the next phase
        c_d.ce_n  = !(c_d.phase inside {ST_READ, ST_WR_HZ, ST_WR_DRV});
        c_d.we_n  = !(c_d.phase inside {ST_WR_HZ, ST_WR_DRV});
        c_d.oe_n  = !(c_d.phase == ST_READ);
        c_d.dq_oe =  (c_d.phase inside {ST_WR_DRV, ST_WR_HOLD});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CTRL_RST;
        else        c_q <= c_d;
    end

    assign req_ready = (c_q.phase == ST_IDLE);
    assign rsp_done  = c_q.done;
    assign mem_ce_n  = c_q.ce_n;
    assign mem_we_n  = c_q.we_n;
    assign mem_oe_n  = c_q.oe_n;
    assign mem_dq_oe = c_q.dq_oe;

    // R5: output enable inactive during a write strobe
    p_write_oe_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R5: never drive while the memory may drive
    p_drive_oe_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R5: drive starts only after a cycle of write strobe with bus released
    p_drive_after_hz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (!mem_we_n && !$past(mem_we_n) && !$past(mem_dq_oe)));

    // R6: data and address held across the end of write
    p_hold_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o) && $stable(mem_addr)));

    // R6: address frozen while busy
    p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

    // R4: completion is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R4: completion coincides with ready and inactive strobes
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (req_ready && mem_ce_n && mem_we_n && mem_oe_n));

    // R2: no acceptance while the chip is selected
    p_busy_when_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

endmodule

// File: tb/async_sram_ctrl_tb.sv
module async_sram_ctrl_tb;
    localparam int CLK   = 10;
    localparam int AW    = 8;
    localparam int DW    = 4;
    localparam int TAA   = 35;
    localparam int TRC   = 30;
    localparam int TWC   = 40;
    localparam int TWP   = 27;
    localparam int TCW   = 25;
    localparam int TAW   = 25;
    localparam int TDS   = 25;
    localparam int THZWE = 12;
    localparam int THZOE = 8;
    localparam int NWORD = 1 << AW;

    function automatic int cy(input int t);
        int c;
        c = (t + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD  = mx(cy(TAA), cy(TRC));
    localparam int E_HZ  = mx(cy(THZWE), cy(THZOE));
    localparam int E_WL  = mx(cy(TWP), mx(cy(TCW), cy(TAW)));
    localparam int E_DRV = mx(mx(cy(TDS), E_WL - E_HZ), mx(cy(TWC) - E_HZ - 1, 1));

    // strobe pack {ce_n, we_n, oe_n, dq_oe}
    localparam logic [3:0] S_IDLE = 4'b1110;
    localparam logic [3:0] S_RD   = 4'b0100;
    localparam logic [3:0] S_HZ   = 4'b0010;
    localparam logic [3:0] S_DRV  = 4'b0011;
    localparam logic [3:0] S_HOLD = 4'b1111;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_o, mem_dq_i;

    int checks = 0;
    int errors = 0;

    always #(CLK/2) clk = ~clk;

    async_sram_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(CLK),
        .T_RC_NS(TRC), .T_AA_NS(TAA), .T_WC_NS(TWC), .T_WP_NS(TWP),
        .T_CW_NS(TCW), .T_AW_NS(TAW), .T_DS_NS(TDS),
        .T_HZWE_NS(THZWE), .T_HZOE_NS(THZOE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Memory model: unknown output until the access time has passed
    logic [DW-1:0] mem_m [NWORD];
    logic [DW-1:0] exp_mem [NWORD];
    int            rd_age = 0;
    logic          rd_mode;
    assign rd_mode  = !mem_ce_n && mem_we_n && !mem_oe_n;
    assign mem_dq_i = (rd_mode && ((rd_age + 1) * CLK >= TAA)) ? mem_m[mem_addr] : 'x;

    always @(posedge clk) begin
        rd_age <= rd_mode ? rd_age + 1 : 0;
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) mem_m[mem_addr] <= mem_dq_o;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe};
    endfunction

    // R5: no contention between memory output and controller drive
    always @(negedge clk) begin
        if (rst_n) chk(!(rd_mode && mem_dq_oe), "R5 contention", 32'(mem_dq_oe), 32'h0);
    end

    bit has_last = 1'b0;
    bit last_wr  = 1'b0;

    task automatic run_op(input bit wr, input int a, input logic [DW-1:0] d);
        bit turn;
        turn = has_last && (last_wr != wr);
        @(negedge clk);
        chk(req_ready === 1'b1, "R2 ready before request", 32'(req_ready), 32'h1);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (turn) begin
            chk(strobes() === S_IDLE && !req_ready, "R7 turnaround", 32'(strobes()), 32'(S_IDLE));
            @(negedge clk);
        end
        if (!wr) begin
            for (int i = 0; i < E_RD; i++) begin
                chk(strobes() === S_RD, "R3 read strobes", 32'(strobes()), 32'(S_RD));
                chk(mem_addr === AW'(a) && !rsp_done, "R3 read address", 32'(mem_addr), 32'(a));
                @(negedge clk);
            end
            chk(rsp_done === 1'b1 && req_ready === 1'b1 && strobes() === S_IDLE,
                "R4 read done", 32'({rsp_done, req_ready, strobes()}), 32'({2'b11, S_IDLE}));
            chk(rsp_rdata === exp_mem[a], "R4 read data", 32'(rsp_rdata), 32'(exp_mem[a]));
            @(negedge clk);
            chk(rsp_done === 1'b0, "R4 done single pulse", 32'(rsp_done), 32'h0);
        end else begin
            exp_mem[a] = d;
            for (int i = 0; i < E_HZ; i++) begin
                chk(strobes() === S_HZ && mem_addr === AW'(a), "R5 write release phase",
                    32'(strobes()), 32'(S_HZ));
                @(negedge clk);
            end
            for (int i = 0; i < E_DRV; i++) begin
                chk(strobes() === S_DRV, "R5 write drive phase", 32'(strobes()), 32'(S_DRV));
                chk(mem_dq_o === d && mem_addr === AW'(a), "R6 write data", 32'(mem_dq_o), 32'(d));
                @(negedge clk);
            end
            chk(strobes() === S_HOLD, "R6 hold cycle strobes", 32'(strobes()), 32'(S_HOLD));
            chk(mem_dq_o === d && mem_addr === AW'(a), "R6 hold data", 32'(mem_dq_o), 32'(d));
            @(negedge clk);
            chk(rsp_done === 1'b1 && req_ready === 1'b1 && strobes() === S_IDLE,
                "R8 write done", 32'({rsp_done, req_ready, strobes()}), 32'({2'b11, S_IDLE}));
            @(negedge clk);
            chk(rsp_done === 1'b0, "R8 done single pulse", 32'(rsp_done), 32'h0);
        end
        has_last = 1'b1;
        last_wr  = wr;
    endtask

    // R2: request pulsed during a busy read is dropped
    task automatic busy_drop(input int a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_wdata = ~exp_mem[a];
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
        chk(rsp_rdata === exp_mem[a], "R2 busy read data", 32'(rsp_rdata), 32'(exp_mem[a]));
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(strobes() === S_IDLE && req_ready === 1'b1, "R2 dropped request stays idle",
                32'(strobes()), 32'(S_IDLE));
        end
        has_last = 1'b1;
        last_wr  = 1'b0;
        run_op(1'b0, a, '0);   // contents unchanged
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(strobes() === S_IDLE && req_ready === 1'b1 && rsp_done === 1'b0,
            "R1 in reset", 32'({strobes(), req_ready, rsp_done}), 32'({S_IDLE, 2'b10}));
        rst_n = 1'b1;
        @(negedge clk);
        chk(strobes() === S_IDLE && req_ready === 1'b1 && rsp_done === 1'b0,
            "R1 after reset", 32'({strobes(), req_ready, rsp_done}), 32'({S_IDLE, 2'b10}));

        for (int a = 0; a < NWORD; a++) run_op(1'b1, a, DW'(a * 7 + 3));
        for (int a = 0; a < NWORD; a++) run_op(1'b0, a, '0);
        for (int a = 0; a < NWORD; a++) begin
            run_op(1'b1, a, DW'(a * 5 + 9));
            run_op(1'b0, a, '0);
        end
        busy_drop(17);
        busy_drop(NWORD - 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule